// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a processor datapath that spends several clock cycles on each instruction and reuses one memory, one ALU and one register file across those cycles. It is a Moore state machine: every datapath control line comes from the current step only, and the instruction's 6-bit operation code only steers which step follows. All instructions share a fetch step and a decode step. After that the machine follows a chain of steps for one of five instruction kinds and then returns to fetch.

The supported kinds are register-to-register arithmetic, word load, word store, branch-if-equal and unconditional jump. Loads take five steps, stores and register arithmetic take four, and branches and jumps take three. An operation code the block does not recognise leaves decode straight back to fetch. A synchronous reset puts the machine in the fetch step. Any control line that a step does not use is driven low.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: One clock edge with `rst` high puts the machine in the fetch step, whatever step it was in before. The reset overrides any advance the current step would have made.
- R2: The fetch step drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00. It is always followed by the decode step.
- R3: The decode step drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00, with every write enable low. The opcode present during decode chooses the next step: 000000 goes to register execute, 100011 and 101011 go to address computation, 000100 goes to branch and 000010 goes to jump.
- R4: A load (100011) runs fetch, decode, address computation, memory read and write-back. Address computation drives `alu_a_sel`=1 and `alu_b_sel`=10. Memory read drives `mem_rd`=1 and `addr_sel`=1. Write-back drives `rf_wr`=1, `wb_sel`=1 and `rf_dst_sel`=0.
- R5: A store (101011) runs fetch, decode, address computation and memory write. Memory write drives `mem_wr`=1 and `addr_sel`=1.
- R6: Register arithmetic (000000) runs fetch, decode, execute and completion. Execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. Completion drives `rf_wr`=1, `rf_dst_sel`=1 and `wb_sel`=0.
- R7: Branch-if-equal (000100) runs fetch, decode and a branch step. The branch step drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_src`=01 and `pc_wr_cond`=1. The next step is fetch.
- R8: A jump (000010) runs fetch, decode and a jump step. The jump step drives `pc_src`=10 and `pc_wr`=1. The next step is fetch.
- R9: Any other opcode seen during decode sends the machine back to fetch on the next edge.
- R10: Every control line that a step does not assign is 0. `mem_rd` and `mem_wr` are never high together, and `mem_wr` and `rf_wr` are never high together.
- R11: Outputs depend only on the step. After the last step that reads the opcode (decode, or address computation for memory instructions), a change of opcode does not alter the outputs or the remaining chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Operation code of the instruction held in the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU reports equality |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result register, 1 memory data register |
| pc_src | output | 2 | Next program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 offset, 11 shifted offset |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
Two events can fall in the same cycle. A reset can arrive in a step that would otherwise move on to the next step of its chain, and the opcode can change in the same cycle that the machine leaves its last opcode-reading step. The bench raises reset during register execute and checks that the next step is fetch, not completion. It also replaces the opcode with one from a different instruction kind right after the deciding step, and checks that the rest of the chain matches the original instruction. On every cycle a behavioural reference queue of expected control words is compared against all sixteen output bits.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_RTYPE  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;

    localparam int SEL2_W = 2;

    // Steps of the sequencer; fetch is the reset step
    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MADDR,
        ST_LDRD,
        ST_LDWB,
        ST_STWR,
        ST_REXE,
        ST_RWB,
        ST_BEQ,
        ST_JMP
    } step_e;

    typedef enum logic [2:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP,
        CL_OTHER
    } opclass_e;

    typedef struct packed {
        logic              pc_wr;
        logic              pc_wr_cond;
        logic              addr_sel;
        logic              mem_rd;
        logic              mem_wr;
        logic              ir_wr;
        logic              wb_sel;
        logic [SEL2_W-1:0] pc_src;
        logic [SEL2_W-1:0] alu_op;
        logic              alu_a_sel;
        logic [SEL2_W-1:0] alu_b_sel;
        logic              rf_wr;
        logic              rf_dst_sel;
    } ctrl_t;

    typedef struct packed {
        step_e step;
    } seq_state_t;

endpackage

// File: rtl/mcf_opclass.sv
module mcf_opclass
    import mcf_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output opclass_e        cls
);
    // Sort the raw opcode into the instruction kind that picks a chain
    always_comb begin
        unique case (opcode)
            OPC_RTYPE:  cls = CL_RTYPE;
            OPC_LOAD:   cls = CL_LOAD;
            OPC_STORE:  cls = CL_STORE;
            OPC_BRANCH: cls = CL_BRANCH;
            OPC_JUMP:   cls = CL_JUMP;
            default:    cls = CL_OTHER;
        endcase
    end
endmodule

// File: rtl/mcf_next.sv
module mcf_next
    import mcf_pkg::*;
(
    input  step_e    cur,
    input  opclass_e cls,
    output step_e    nxt
);
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_RTYPE:          nxt = ST_REXE;
                    CL_LOAD, CL_STORE: nxt = ST_MADDR;
                    CL_BRANCH:         nxt = ST_BEQ;
                    CL_JUMP:           nxt = ST_JMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_MADDR: begin
                // second and last opcode-dependent split
                if (cls == CL_LOAD)       nxt = ST_LDRD;
                else if (cls == CL_STORE) nxt = ST_STWR;
                else                      nxt = ST_FETCH;
            end
            ST_LDRD:   nxt = ST_LDWB;
            ST_REXE:   nxt = ST_RWB;
            ST_LDWB, ST_STWR, ST_RWB, ST_BEQ, ST_JMP: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcf_outdec.sv
module mcf_outdec
    import mcf_pkg::*;
(
    input  step_e cur,
    output ctrl_t ctl
);
    // Moore decode: outputs follow the step alone; unused lines stay 0
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b11;
            end
            ST_MADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.wb_sel = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_RWB: begin
                ctl.rf_wr      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BEQ: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_src     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
            end
            ST_JMP: begin
                ctl.pc_src = 2'b10;
                ctl.pc_wr  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic              pc_wr,
    output logic              pc_wr_cond,
    output logic              addr_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ir_wr,
    output logic              wb_sel,
    output logic [SEL2_W-1:0] pc_src,
    output logic [SEL2_W-1:0] alu_op,
    output logic              alu_a_sel,
    output logic [SEL2_W-1:0] alu_b_sel,
    output logic              rf_wr,
    output logic              rf_dst_sel
);
    seq_state_t st_d, st_q;
    opclass_e   cls;
    step_e      step_adv;
    ctrl_t      ctl;

    mcf_opclass u_cls (
        .opcode (opcode),
        .cls    (cls)
    );

    mcf_next u_next (
        .cur (st_q.step),
        .cls (cls),
        .nxt (step_adv)
    );

    mcf_outdec u_dec (
        .cur (st_q.step),
        .ctl (ctl)
    );

    // next value: reset takes precedence over any advance
    always_comb begin
        st_d = st_q;
        if (rst) st_d.step = ST_FETCH;
        else     st_d.step = step_adv;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_sel   = ctl.addr_sel;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign wb_sel     = ctl.wb_sel;
    assign pc_src     = ctl.pc_src;
    assign alu_op     = ctl.alu_op;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign rf_wr      = ctl.rf_wr;
    assign rf_dst_sel = ctl.rf_dst_sel;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk
    import mcf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   opcode,
    input logic              pc_wr,
    input logic              pc_wr_cond,
    input logic              addr_sel,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              ir_wr,
    input logic              wb_sel,
    input logic [SEL2_W-1:0] pc_src,
    input logic [SEL2_W-1:0] alu_op,
    input logic              alu_a_sel,
    input logic [SEL2_W-1:0] alu_b_sel,
    input logic              rf_wr,
    input logic              rf_dst_sel
);
    logic in_fetch, in_decode, op_known;
    assign in_fetch  = ir_wr && mem_rd && pc_wr && (alu_b_sel == 2'b01) && !addr_sel;
    assign in_decode = (alu_b_sel == 2'b11) && !alu_a_sel;
    assign op_known  = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) || (opcode == OPC_STORE)
                    || (opcode == OPC_BRANCH) || (opcode == OPC_JUMP);

    AST_RESET_FETCH: assert property (@(posedge clk) rst |=> in_fetch); // R1
    AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst) in_fetch |=> in_decode); // R2
    AST_DECODE_MEM: assert property (@(posedge clk) disable iff (rst)
        (in_decode && (opcode == OPC_LOAD || opcode == OPC_STORE)) |=> (alu_a_sel && alu_b_sel == 2'b10)); // R3
    AST_LOAD_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (rf_wr && wb_sel && !rf_dst_sel)); // R4
    AST_STORE_DONE: assert property (@(posedge clk) disable iff (rst) mem_wr |=> in_fetch); // R5
    AST_RTYPE_DONE: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10) |=> (rf_wr && rf_dst_sel && !wb_sel)); // R6
    AST_BRANCH_DONE: assert property (@(posedge clk) disable iff (rst) pc_wr_cond |=> in_fetch); // R7
    AST_JUMP_DONE: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'b10) |=> in_fetch); // R8
    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        (in_decode && !op_known) |=> in_fetch); // R9
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R10
    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_wr && rf_wr)); // R10
    AST_PCSRC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr || pc_wr_cond) |-> (pc_src == 2'b00)); // R10
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (.*);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, rf_wr, rf_dst_sel;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [15:0] expq[$];
    logic [15:0] W_FETCH, W_DECODE, W_MADDR, W_LDRD, W_LDWB, W_STWR, W_REXE, W_RWB, W_BEQ, W_JMP;

    always #5 clk = ~clk;

    mc_ctrl_fsm uut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
        .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
    );

    function automatic logic [15:0] word(input bit pcw, pcc, iord, mrd, mwr, irw, m2r,
                                         input logic [1:0] psrc, aop, input bit asel,
                                         input logic [1:0] bsel, input bit rfw, rdst);
        return {pcw, pcc, iord, mrd, mwr, irw, m2r, psrc, aop, asel, bsel, rfw, rdst};
    endfunction

    function automatic logic [15:0] observed();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
                pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
    endfunction

    task automatic cmp(input logic [15:0] exp, input string tag, input int idx);
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual=%b expected=%b", tag, idx, observed(), exp);
        end
    endtask

    // Reference: list of control words an instruction produces, per requirement
    task automatic build(input logic [5:0] op);
        expq = {};
        expq.push_back(W_FETCH);
        expq.push_back(W_DECODE);
        case (op)
            6'b100011: begin expq.push_back(W_MADDR); expq.push_back(W_LDRD); expq.push_back(W_LDWB); end
            6'b101011: begin expq.push_back(W_MADDR); expq.push_back(W_STWR); end
            6'b000000: begin expq.push_back(W_REXE); expq.push_back(W_RWB); end
            6'b000100: expq.push_back(W_BEQ);
            6'b000010: expq.push_back(W_JMP);
            default: ;
        endcase
    endtask

    // Called at a falling edge while the machine is in fetch
    task automatic run(input logic [5:0] op, input int garble_at, input logic [5:0] alt, input string tag);
        build(op);
        opcode = op;
        for (int i = 0; i < expq.size(); i++) begin
            if (i > 0) @(negedge clk);
            cmp(expq[i], tag, i);
            if (garble_at > 0 && i == garble_at) opcode = alt;
        end
        @(negedge clk);
    endtask

    initial begin
        W_FETCH  = word(1,0,0,1,0,1,0,2'b00,2'b00,0,2'b01,0,0);
        W_DECODE = word(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
        W_MADDR  = word(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
        W_LDRD   = word(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
        W_LDWB   = word(0,0,0,0,0,0,1,2'b00,2'b00,0,2'b00,1,0);
        W_STWR   = word(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
        W_REXE   = word(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
        W_RWB    = word(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
        W_BEQ    = word(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
        W_JMP    = word(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);

        repeat (2) @(negedge clk);
        rst = 1'b0;
        cmp(W_FETCH, "R1 reset", 0);

        run(6'b100011, 0, 6'b0, "R4 load");
        run(6'b101011, 0, 6'b0, "R5 store");
        run(6'b000000, 0, 6'b0, "R6 rtype");
        run(6'b000100, 0, 6'b0, "R7 branch");
        run(6'b000010, 0, 6'b0, "R8 jump");
        run(6'b111111, 0, 6'b0, "R9 unknown");
        run(6'b010101, 0, 6'b0, "R9 unknown2");
        run(6'b100011, 0, 6'b0, "R3 R2 load again");

        // R11: opcode swapped right after the last step that reads it
        run(6'b000000, 2, 6'b100011, "R11 rtype->load");
        run(6'b100011, 3, 6'b101011, "R11 load->store");
        run(6'b101011, 3, 6'b100011, "R11 store->load");
        run(6'b000100, 2, 6'b000000, "R11 branch->rtype");

        // R1: reset in the execute step wins over the advance to completion
        opcode = 6'b000000;
        cmp(W_FETCH, "R1 pre", 0);
        @(negedge clk); cmp(W_DECODE, "R1 pre", 1);
        @(negedge clk); cmp(W_REXE, "R1 pre", 2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cmp(W_FETCH, "R1 mid-chain reset", 3);

        run(6'b000010, 0, 6'b0, "R10 R8 after reset");
        run(6'b000000, 0, 6'b0, "R10 R6 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule